// File: doc/BRIEF.md
# Banked Memory Mapper Register File

This block sits on the processor write path of a cartridge and holds the bank-select state that a memory mapper needs. It watches a write strobe, a 16-bit address and a data byte. It stores bank numbers for two switchable 8 KB program windows and for eight 1 KB character windows. It also stores a nametable mirroring code and a slot-swap mode bit. Before any decode, the address is masked with 0xF0CF. Several masked addresses can therefore land on the same register.

Each character bank number is eight bits wide. It is built from two separate writes, and each write delivers one nibble in data bits [3:0]. The two program windows that are not switchable always show the second-to-last and the last program bank. The total bank count N arrives on an input port. The swap mode bit decides whether the first switchable register feeds the $8000 window or the $C000 window.

Top module: `bank_map_regs`

## Requirements
- R1: After reset, character bank i reads i (i = 0..7). The program windows $8000, $A000, $C000 and $E000 read 0, 1, N-2 and N-1. The mirroring code reads 0 and swap mode is off.
- R2: The address is ANDed with 0xF0CF before decode. For example, a write to 0xBF32 acts exactly like a write to 0xB002.
- R3: A write to 0x8000 loads the first switchable program register with the data byte. While swap mode is off, that register drives the $8000 window. While swap mode is on, it drives the $C000 window. Changing the mode moves the register between the two windows without rewriting it.
- R4: A write to 0xA000 loads the $A000 window bank with the data byte.
- R5: Of $8000 and $C000, the window not driven by the first switchable register reads N-2. The $E000 window always reads N-1.
- R6: A write to 0x9000 sets the mirroring output to data[1:0]. The codes are 0 vertical, 1 horizontal, 2 single-screen low and 3 single-screen high.
- R7: A write to 0x9002 or to 0x9080 sets swap mode to data bit 1. The other data bits have no effect.
- R8: A low-nibble write to a character bank replaces bits [3:0] with data[3:0] and keeps bits [7:4].
- R9: A high-nibble write to a character bank replaces bits [7:4] with data[3:0] and keeps bits [3:0].
- R10: Address groups 0xB, 0xC, 0xD and 0xE select the bank pairs 0/1, 2/3, 4/5 and 6/7. The low 8 bits of the masked address pick the bank and the nibble:
  - Even bank, low nibble: offset 0x00.
  - Even bank, high nibble: offset 0x02 or 0x40.
  - Odd bank, low nibble: offset 0x01, 0x04 or 0x80.
  - Odd bank, high nibble: offset 0x03, 0x06 or 0xC0.
- R11: The following change no state: a write with the strobe low, a write below 0x8000, and a write to a masked address that matches no register (for example 0xF000 or 0xB008).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 16 | Write address |
| wdata | input | 8 | Write data |
| prg_bank_count | input | PRG_W | Total number of 8 KB program banks (N) |
| prg_bank_o | output | 4 x PRG_W | Program bank per window; index 0..3 = $8000, $A000, $C000, $E000 |
| chr_bank_o | output | 8 x 8 | Character bank numbers, index = bank slot |
| mirror_o | output | 2 | Mirroring code |

## Verification
The assertions assume three things about the inputs:
- prg_bank_count is at least 2 and changes only while reset is held.
- The address and data carry no unknown values whenever the strobe is high.
- No write arrives during the two cycles in which the reset release is still being synchronized.

The stimulus follows these rules. It changes the bank count only around a reset pulse. It waits several cycles after releasing reset before its first write. It drives every write on the falling clock edge, with defined address and data, and lowers the strobe one cycle later.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  localparam int DATA_W   = 8;
  localparam int CHR_SLOTS = 8;
  localparam int CHR_IDX_W = $clog2(CHR_SLOTS);
  localparam logic [15:0] ADDR_MASK = 16'hF0CF;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_PRG_SW,
    TGT_PRG_MID,
    TGT_MIRROR,
    TGT_MODE,
    TGT_CHR
  } target_e;

  typedef struct packed {
    target_e              tgt;
    logic [CHR_IDX_W-1:0] chr_idx;
    logic                 hi_nib;
  } wr_dec_t;
endpackage

// File: rtl/bmr_rst_sync.sv
module bmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/bmr_decode.sv
module bmr_decode
  import bmr_pkg::*;
(
  input  logic        wr_en,
  input  logic [15:0] addr,
  output wr_dec_t     dec
);
  logic [15:0] masked;
  logic [1:0]  pair;
  logic        grp_chr;

  assign masked = addr & ADDR_MASK;

  always_comb begin
    grp_chr = 1'b1;
    pair    = 2'd0;
    case (masked[15:12])
      4'hB:    pair = 2'd0;
      4'hC:    pair = 2'd1;
      4'hD:    pair = 2'd2;
      4'hE:    pair = 2'd3;
      default: grp_chr = 1'b0;
    endcase
  end

  always_comb begin
    dec = '{tgt: TGT_NONE, chr_idx: '0, hi_nib: 1'b0};
    if (wr_en) begin
      if (grp_chr) begin
        case (masked[11:0])
          12'h000:                   dec = '{tgt: TGT_CHR, chr_idx: {pair, 1'b0}, hi_nib: 1'b0};
          12'h002, 12'h040:          dec = '{tgt: TGT_CHR, chr_idx: {pair, 1'b0}, hi_nib: 1'b1};
          12'h001, 12'h004, 12'h080: dec = '{tgt: TGT_CHR, chr_idx: {pair, 1'b1}, hi_nib: 1'b0};
          12'h003, 12'h006, 12'h0C0: dec = '{tgt: TGT_CHR, chr_idx: {pair, 1'b1}, hi_nib: 1'b1};
          default: ;
        endcase
      end else begin
        case (masked)
          16'h8000:           dec.tgt = TGT_PRG_SW;
          16'hA000:           dec.tgt = TGT_PRG_MID;
          16'h9000:           dec.tgt = TGT_MIRROR;
          16'h9002, 16'h9080: dec.tgt = TGT_MODE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmr_chr_regs.sv
module bmr_chr_regs
  import bmr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [CHR_IDX_W-1:0]           idx,
  input  logic                           hi_nib,
  input  logic [3:0]                     nib,
  output logic [CHR_SLOTS-1:0][DATA_W-1:0] bank_q
);
  for (genvar i = 0; i < CHR_SLOTS; i++) begin : g_slot
    logic              en;
    logic [DATA_W-1:0] bank_d;

    assign en = wr && (idx == CHR_IDX_W'(i));

    always_comb begin
      bank_d = bank_q[i];
      if (hi_nib) bank_d[7:4] = nib;
      else        bank_d[3:0] = nib;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank_q[i] <= DATA_W'(i);
      else if (en) bank_q[i] <= bank_d;
    end
  end
endmodule

// File: rtl/bank_map_regs.sv
module bank_map_regs
  import bmr_pkg::*;
#(
  parameter int PRG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [15:0]               addr,
  input  logic [7:0]                wdata,
  input  logic [PRG_W-1:0]          prg_bank_count,
  output logic [3:0][PRG_W-1:0]     prg_bank_o,
  output logic [7:0][7:0]           chr_bank_o,
  output logic [1:0]                mirror_o
);
  localparam logic [PRG_W-1:0] ONE = PRG_W'(1);

  logic       rst_n_sync;
  wr_dec_t    dec;

  logic [PRG_W-1:0] prg_sw_q, prg_sw_d;
  logic [PRG_W-1:0] prg_mid_q, prg_mid_d;
  logic [1:0]       mirror_q, mirror_d;
  logic             swap_q, swap_d;
  logic             en_sw, en_mid, en_mir, en_mode;
  logic [PRG_W-1:0] fixed_lo, fixed_hi;

  bmr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bmr_decode u_decode (
    .wr_en (wr_en),
    .addr  (addr),
    .dec   (dec)
  );

  bmr_chr_regs u_chr (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr     (dec.tgt == TGT_CHR),
    .idx    (dec.chr_idx),
    .hi_nib (dec.hi_nib),
    .nib    (wdata[3:0]),
    .bank_q (chr_bank_o)
  );

  // Clock enables per register
  assign en_sw   = (dec.tgt == TGT_PRG_SW);
  assign en_mid  = (dec.tgt == TGT_PRG_MID);
  assign en_mir  = (dec.tgt == TGT_MIRROR);
  assign en_mode = (dec.tgt == TGT_MODE);

  // Next-state
  always_comb begin
    prg_sw_d  = wdata[PRG_W-1:0];
    prg_mid_d = wdata[PRG_W-1:0];
    mirror_d  = wdata[1:0];
    swap_d    = wdata[1];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      prg_sw_q  <= '0;
      prg_mid_q <= ONE;
      mirror_q  <= 2'd0;
      swap_q    <= 1'b0;
    end else begin
      if (en_sw)   prg_sw_q  <= prg_sw_d;
      if (en_mid)  prg_mid_q <= prg_mid_d;
      if (en_mir)  mirror_q  <= mirror_d;
      if (en_mode) swap_q    <= swap_d;
    end
  end

  // Window mapping
  assign fixed_hi = prg_bank_count - ONE;
  assign fixed_lo = prg_bank_count - (ONE + ONE);

  always_comb begin
    prg_bank_o[0] = swap_q ? fixed_lo : prg_sw_q;
    prg_bank_o[1] = prg_mid_q;
    prg_bank_o[2] = swap_q ? prg_sw_q : fixed_lo;
    prg_bank_o[3] = fixed_hi;
  end

  assign mirror_o = mirror_q;
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int PRG_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [15:0]           addr,
  input logic [7:0]            wdata,
  input logic [PRG_W-1:0]      prg_bank_count,
  input logic [3:0][PRG_W-1:0] prg_bank_o,
  input logic [7:0][7:0]       chr_bank_o,
  input logic [1:0]            mirror_o
);
  logic [15:0] m;
  assign m = addr & 16'hF0CF;

  // R5
  top_window_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_bank_o[3] == prg_bank_count - PRG_W'(1)) &&
    ((prg_bank_o[0] == prg_bank_count - PRG_W'(2)) ||
     (prg_bank_o[2] == prg_bank_count - PRG_W'(2))));

  // R4
  mid_window_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && m == 16'hA000) |=> (prg_bank_o[1] == $past(wdata[PRG_W-1:0])));

  // R6
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && m == 16'h9000) |=> (mirror_o == $past(wdata[1:0])));

  // R8
  chr0_low_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && m == 16'hB000) |=>
      (chr_bank_o[0][3:0] == $past(wdata[3:0])) &&
      (chr_bank_o[0][7:4] == $past(chr_bank_o[0][7:4])));

  // R9
  chr1_high_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && m == 16'hB0C0) |=>
      (chr_bank_o[1][7:4] == $past(wdata[3:0])) &&
      (chr_bank_o[1][3:0] == $past(chr_bank_o[1][3:0])));

  // R11
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || !addr[15]) |=>
      $stable(chr_bank_o) && $stable(mirror_o) && $stable(prg_bank_o[1]));
endmodule

bind bank_map_regs bmr_checker #(.PRG_W(PRG_W)) u_bmr_checker (.*);

// File: tb/bank_map_regs_tb_top.sv
`timescale 1ns/1ps
module bank_map_regs_tb_top;
  localparam int PRG_W = 8;
  localparam int NV = 22;

  logic                  clk;
  logic                  rst_n;
  logic                  wr_en;
  logic [15:0]           addr;
  logic [7:0]            wdata;
  logic [PRG_W-1:0]      prg_bank_count;
  logic [3:0][PRG_W-1:0] prg_bank_o;
  logic [7:0][7:0]       chr_bank_o;
  logic [1:0]            mirror_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bank_map_regs #(.PRG_W(PRG_W)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .addr           (addr),
    .wdata          (wdata),
    .prg_bank_count (prg_bank_count),
    .prg_bank_o     (prg_bank_o),
    .chr_bank_o     (chr_bank_o),
    .mirror_o       (mirror_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {addr, data, sel, expected}; sel 0..3 program window, 4..11 char bank, 12 mirror
  // Bank count N = 16 for this walk.
  localparam logic [35:0] VEC [0:NV-1] = '{
    {16'h8000, 8'h05, 4'd0,  8'h05},  // R3 swap off -> $8000 window
    {16'hA000, 8'h09, 4'd1,  8'h09},  // R4
    {16'h9000, 8'h01, 4'd12, 8'h01},  // R6 horizontal
    {16'h9000, 8'hFE, 4'd12, 8'h02},  // R6 single low, upper bits dropped
    {16'h9000, 8'h03, 4'd12, 8'h03},  // R6 single high
    {16'hB000, 8'h3A, 4'd4,  8'h0A},  // R8
    {16'hB002, 8'h0C, 4'd4,  8'hCA},  // R9
    {16'hB040, 8'h05, 4'd4,  8'h5A},  // R9 alias
    {16'hB001, 8'h07, 4'd5,  8'h07},  // R10 odd low
    {16'hB0C0, 8'h02, 4'd5,  8'h27},  // R10 odd high alias
    {16'hC004, 8'h0E, 4'd7,  8'h0E},  // R10
    {16'hC006, 8'h01, 4'd7,  8'h1E},  // R10
    {16'hD080, 8'h09, 4'd9,  8'h09},  // R10
    {16'hD003, 8'h0B, 4'd9,  8'hB9},  // R10
    {16'hE003, 8'h0F, 4'd11, 8'hF7},  // R10
    {16'hE040, 8'h04, 4'd10, 8'h46},  // R10
    {16'hC000, 8'hF2, 4'd6,  8'h02},  // R8
    {16'hBF32, 8'h08, 4'd4,  8'h8A},  // R2 masked to B002
    {16'h3002, 8'h01, 4'd4,  8'h8A},  // R11 below 0x8000
    {16'hF000, 8'h01, 4'd4,  8'h8A},  // R11 undecoded
    {16'hB008, 8'h01, 4'd4,  8'h8A},  // R11 undecoded offset
    {16'h9001, 8'h00, 4'd12, 8'h03}   // R11 undecoded near mirror
  };

  function automatic logic [7:0] pick(input logic [3:0] s);
    logic [3:0] t;
    t = s - 4'd4;
    if (s < 4'd4)       return 8'(prg_bank_o[s[1:0]]);
    else if (s < 4'd12) return chr_bank_o[t[2:0]];
    else                return {6'd0, mirror_o};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    wr_en = en; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic [PRG_W-1:0] n);
    @(negedge clk);
    rst_n = 1'b0;
    prg_bank_count = n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    wr_en = 1'b0; addr = '0; wdata = '0; rst_n = 1'b0; prg_bank_count = 8'd16;
    do_reset(8'd16);

    // R1 reset state
    for (int i = 0; i < 8; i++) check("R1 chr reset", chr_bank_o[i], 8'(i));
    check("R1 prg $8000", prg_bank_o[0], 8'd0);
    check("R1 prg $A000", prg_bank_o[1], 8'd1);
    check("R1 prg $C000", prg_bank_o[2], 8'd14);
    check("R1 prg $E000", prg_bank_o[3], 8'd15);
    check("R1 mirror", {6'd0, mirror_o}, 8'd0);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][35:20], VEC[v][19:12]);
      check($sformatf("vector %0d (R2/R3/R4/R6/R8/R9/R10/R11)", v),
            pick(VEC[v][11:8]), VEC[v][7:0]);
    end

    // R11 strobe low
    wr(16'h8000, 8'hAA, 1'b0);
    check("R11 strobe low prg", prg_bank_o[0], 8'h05);

    // R7 / R3 / R5 swap mode
    wr(16'h9002, 8'h02);
    check("R7 swap on $8000", prg_bank_o[0], 8'd14);
    check("R3 swap on $C000", prg_bank_o[2], 8'h05);
    wr(16'h8000, 8'h33);
    check("R3 load under swap $C000", prg_bank_o[2], 8'h33);
    check("R5 swap $8000 fixed", prg_bank_o[0], 8'd14);
    check("R5 $E000 fixed", prg_bank_o[3], 8'd15);
    wr(16'h9080, 8'hFD);
    check("R7 alias bit1 clear $8000", prg_bank_o[0], 8'h33);
    check("R5 $C000 fixed", prg_bank_o[2], 8'd14);

    // R1 / R5 with a different bank count
    do_reset(8'd200);
    check("R1 N=200 $C000", prg_bank_o[2], 8'd198);
    check("R1 N=200 $E000", prg_bank_o[3], 8'd199);
    check("R1 N=200 chr0", chr_bank_o[0], 8'd0);
    check("R1 N=200 mirror", {6'd0, mirror_o}, 8'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule